// File: doc/BRIEF.md
# Custom Opcode Dispatcher with Run-Time Selector

This block sits between the decode stage of a 32-bit core and an external custom function unit (CFU) port. It handles the three custom opcode spaces: custom-0 (`7'h0B`), custom-1 (`7'h2B`) and custom-2 (`7'h5B`). Software programs a selector register through a CSR write. The selector holds an enable flag, a unit number and a state-context number. The value stays in place, so any number of later custom instructions can use it without a rewrite.

When the enable flag is set, each custom instruction becomes a valid/ready request. The request carries the function bits, two register operands and the selector's two identifiers. The instruction then waits for a valid/ready response and ends with a register writeback. When the enable flag is clear, no request ever leaves the block. In that case the instruction either runs on a small built-in function set inside the block or ends in an illegal-instruction trap. Operands come only from the register file and results go only to it; the block makes no memory access.

Top module: `cfu_dispatch`

## Requirements
- R1: After reset the selector reads back as zero. `req_valid`, `rsp_ready`, `wb_valid`, `trap`, `bi_fire` and `busy` are all low.
- R2: A CSR write at address `SEL_ADDR` stores the enable flag from bit 0, the unit number from bits [15:8] and the state number from bits [23:16]. A read at that address returns those fields in the same positions with every other bit zero. A read at any other address returns zero, and a write at any other address leaves the selector unchanged.
- R3: While the enable flag is 0, no custom instruction raises `req_valid` or `busy`, whatever unit and state numbers are stored.
- R4: While the enable flag is 0, a custom-0 or custom-1 instruction with funct3 below 4 completes on the built-in path. One cycle after acceptance, `wb_valid` and `bi_fire` pulse together. `wb_data` is then rs1+rs2 for funct3=0, rs1 XOR rs2 for funct3=1, the unsigned minimum for funct3=2, and rs1 rotated left by rs2[4:0] for funct3=3.
- R5: While the enable flag is 0, any other custom instruction (custom-2, or funct3 of 4 to 7) pulses `trap` one cycle after acceptance, with no `wb_valid`.
- R6: While the enable flag is 1, the cycle after acceptance shows `req_valid` and `busy` high. The request then carries `{funct7,funct3}`, both operands and the stored unit and state numbers.
- R7: The request payload holds steady until `req_ready`. Only one request is outstanding at a time. `busy` stays high until the response handshake, and a new instruction is accepted only while `busy` is low.
- R8: A response with `rsp_err`=0, taken while `rsp_ready` is high, produces `wb_valid` with `wb_data` equal to the response data in the next cycle. `busy` falls in that same cycle.
- R9: A response with `rsp_err`=1 produces `trap` in the next cycle and no `wb_valid`.
- R10: A selector write while a request is in flight leaves that request's identifiers unchanged. The next custom instruction uses the new value.
- R11: Instructions outside the three custom opcodes are ignored: no request, writeback, trap or busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data for `csr_addr` |
| ins_valid | input | 1 | Decoded instruction present |
| ins_opcode | input | 7 | Major opcode |
| ins_funct3 | input | 3 | funct3 field |
| ins_funct7 | input | 7 | funct7 field |
| ins_rs1 | input | 32 | First source operand |
| ins_rs2 | input | 32 | Second source operand |
| busy | output | 1 | Dispatcher occupied; hold the next instruction |
| req_valid | output | 1 | CFU request valid |
| req_ready | input | 1 | CFU request accepted |
| req_funct | output | 10 | `{funct7,funct3}` |
| req_op_a | output | 32 | Operand A |
| req_op_b | output | 32 | Operand B |
| req_cfu_id | output | 8 | Target unit number |
| req_state_id | output | 8 | State context number |
| rsp_valid | input | 1 | CFU response valid |
| rsp_ready | output | 1 | Dispatcher takes the response |
| rsp_data | input | 32 | Response data |
| rsp_err | input | 1 | Response error flag |
| wb_valid | output | 1 | Writeback strobe |
| wb_data | output | 32 | Writeback value |
| trap | output | 1 | Illegal-instruction trap pulse |
| bi_fire | output | 1 | Built-in path strobe |

## Verification
The bench uses the default build: 32-bit operands, selector at `12'hBC0`, built-in functions on custom-0 and custom-1, and four built-in operations. This choice lets a disabled custom-2 instruction reach the trap path, and funct3 values 4 to 7 reach it too. Request and response delays from zero to several cycles exercise the held payload, the single outstanding request and a selector rewrite in mid-flight. Error responses exercise the trap that replaces a writeback.

// File: rtl/cfu_pkg.sv
package cfu_pkg;

    localparam logic [6:0] OPC_CUST0 = 7'h0B;
    localparam logic [6:0] OPC_CUST1 = 7'h2B;
    localparam logic [6:0] OPC_CUST2 = 7'h5B;

    // Selector field widths are fixed by the register layout.
    localparam int SEL_ID_W  = 8;
    localparam int SEL_CFU_LO = 8;
    localparam int SEL_ST_LO  = 16;

    typedef struct packed {
        logic                en;
        logic [SEL_ID_W-1:0] cfu_id;
        logic [SEL_ID_W-1:0] state_id;
    } sel_t;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_REQ  = 2'd1,
        SEQ_RSP  = 2'd2
    } seq_state_e;

    // One-hot custom space: bit0 custom-0, bit1 custom-1, bit2 custom-2.
    function automatic logic [2:0] custom_space(input logic [6:0] opc);
        logic [2:0] s;
        s[0] = (opc == OPC_CUST0);
        s[1] = (opc == OPC_CUST1);
        s[2] = (opc == OPC_CUST2);
        return s;
    endfunction

endpackage

// File: rtl/cfu_sel_csr.sv
module cfu_sel_csr
    import cfu_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter int              ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] SEL_ADDR = 12'hBC0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [XLEN-1:0]   wdata,
    output logic [XLEN-1:0]   rdata,
    output sel_t              sel
);
    localparam int ST_HI  = SEL_ST_LO + SEL_ID_W - 1;
    localparam int CFU_HI = SEL_CFU_LO + SEL_ID_W - 1;

    logic hit;
    assign hit = (addr == SEL_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel <= '0;
        end else if (we && hit) begin
            sel.en       <= wdata[0];
            sel.cfu_id   <= wdata[CFU_HI:SEL_CFU_LO];
            sel.state_id <= wdata[ST_HI:SEL_ST_LO];
        end
    end

    always_comb begin
        rdata = '0;
        if (hit) begin
            rdata[0]                 = sel.en;
            rdata[CFU_HI:SEL_CFU_LO] = sel.cfu_id;
            rdata[ST_HI:SEL_ST_LO]   = sel.state_id;
        end
    end
endmodule

// File: rtl/cfu_builtin.sv
module cfu_builtin
    import cfu_pkg::*;
#(
    parameter int         XLEN      = 32,
    parameter logic [2:0] BI_SPACES = 3'b011,
    parameter int         BI_OPS    = 4
) (
    input  logic [6:0]      opc,
    input  logic [2:0]      funct3,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic            hit,
    output logic [XLEN-1:0] result
);
    localparam int SH_W = $clog2(XLEN);

    logic [2:0]          space;
    logic [2*XLEN-1:0]   rot_dbl;
    logic [XLEN-1:0]     op_res [BI_OPS];

    assign space   = custom_space(opc);
    assign hit     = ((space & BI_SPACES) != 3'b000) && (int'(funct3) < BI_OPS);
    assign rot_dbl = {a, a} << b[SH_W-1:0];

    // One result lane per implemented operation.
    for (genvar g = 0; g < BI_OPS; g++) begin : g_op
        if (g == 0) begin : g_add
            assign op_res[g] = a + b;
        end else if (g == 1) begin : g_xor
            assign op_res[g] = a ^ b;
        end else if (g == 2) begin : g_minu
            assign op_res[g] = (a < b) ? a : b;
        end else if (g == 3) begin : g_rotl
            assign op_res[g] = rot_dbl[2*XLEN-1:XLEN];
        end else begin : g_zero
            assign op_res[g] = '0;
        end
    end

    always_comb begin
        result = '0;
        for (int i = 0; i < BI_OPS; i++) begin
            if (int'(funct3) == i) result = op_res[i];
        end
    end
endmodule

// File: rtl/cfu_seq.sv
module cfu_seq
    import cfu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ins_valid,
    input  logic                ins_custom,
    input  logic [9:0]          ins_funct,
    input  logic [XLEN-1:0]     ins_rs1,
    input  logic [XLEN-1:0]     ins_rs2,
    input  sel_t                sel,
    input  logic                bi_hit,
    input  logic [XLEN-1:0]     bi_result,
    output logic                busy,
    output logic                req_valid,
    input  logic                req_ready,
    output logic [9:0]          req_funct,
    output logic [XLEN-1:0]     req_op_a,
    output logic [XLEN-1:0]     req_op_b,
    output logic [SEL_ID_W-1:0] req_cfu_id,
    output logic [SEL_ID_W-1:0] req_state_id,
    input  logic                rsp_valid,
    output logic                rsp_ready,
    input  logic [XLEN-1:0]     rsp_data,
    input  logic                rsp_err,
    output logic                wb_valid,
    output logic [XLEN-1:0]     wb_data,
    output logic                trap,
    output logic                bi_fire
);
    seq_state_e state;
    logic       accept;

    assign accept    = ins_valid && ins_custom && (state == SEQ_IDLE);
    assign busy      = (state != SEQ_IDLE);
    assign req_valid = (state == SEQ_REQ);
    assign rsp_ready = (state == SEQ_RSP);

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= SEQ_IDLE;
            wb_valid     <= 1'b0;
            wb_data      <= '0;
            trap         <= 1'b0;
            bi_fire      <= 1'b0;
            req_funct    <= '0;
            req_op_a     <= '0;
            req_op_b     <= '0;
            req_cfu_id   <= '0;
            req_state_id <= '0;
        end else begin
            wb_valid <= 1'b0;
            trap     <= 1'b0;
            bi_fire  <= 1'b0;
            unique case (state)
                SEQ_IDLE: begin
                    if (accept) begin
                        if (sel.en) begin
                            state        <= SEQ_REQ;
                            req_funct    <= ins_funct;
                            req_op_a     <= ins_rs1;
                            req_op_b     <= ins_rs2;
                            req_cfu_id   <= sel.cfu_id;
                            req_state_id <= sel.state_id;
                        end else if (bi_hit) begin
                            wb_valid <= 1'b1;
                            bi_fire  <= 1'b1;
                            wb_data  <= bi_result;
                        end else begin
                            trap <= 1'b1;
                        end
                    end
                end
                SEQ_REQ: begin
                    if (req_ready) state <= SEQ_RSP;
                end
                SEQ_RSP: begin
                    if (rsp_valid) begin
                        state <= SEQ_IDLE;
                        if (rsp_err) begin
                            trap <= 1'b1;
                        end else begin
                            wb_valid <= 1'b1;
                            wb_data  <= rsp_data;
                        end
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cfu_dispatch.sv
module cfu_dispatch
    import cfu_pkg::*;
#(
    parameter int         XLEN      = 32,
    parameter int         ADDR_W    = 12,
    parameter logic [11:0] SEL_ADDR = 12'hBC0,
    parameter logic [2:0] BI_SPACES = 3'b011,
    parameter int         BI_OPS    = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                csr_we,
    input  logic [ADDR_W-1:0]   csr_addr,
    input  logic [XLEN-1:0]     csr_wdata,
    output logic [XLEN-1:0]     csr_rdata,
    input  logic                ins_valid,
    input  logic [6:0]          ins_opcode,
    input  logic [2:0]          ins_funct3,
    input  logic [6:0]          ins_funct7,
    input  logic [XLEN-1:0]     ins_rs1,
    input  logic [XLEN-1:0]     ins_rs2,
    output logic                busy,
    output logic                req_valid,
    input  logic                req_ready,
    output logic [9:0]          req_funct,
    output logic [XLEN-1:0]     req_op_a,
    output logic [XLEN-1:0]     req_op_b,
    output logic [SEL_ID_W-1:0] req_cfu_id,
    output logic [SEL_ID_W-1:0] req_state_id,
    input  logic                rsp_valid,
    output logic                rsp_ready,
    input  logic [XLEN-1:0]     rsp_data,
    input  logic                rsp_err,
    output logic                wb_valid,
    output logic [XLEN-1:0]     wb_data,
    output logic                trap,
    output logic                bi_fire
);
    sel_t            sel;
    logic            sel_en;
    logic            ins_custom;
    logic            bi_hit;
    logic [XLEN-1:0] bi_result;

    assign ins_custom = (custom_space(ins_opcode) != 3'b000);
    assign sel_en     = sel.en;

    cfu_sel_csr #(.XLEN(XLEN), .ADDR_W(ADDR_W), .SEL_ADDR(SEL_ADDR[ADDR_W-1:0])) u_sel (
        .clk(clk), .rst(rst), .we(csr_we), .addr(csr_addr),
        .wdata(csr_wdata), .rdata(csr_rdata), .sel(sel)
    );

    cfu_builtin #(.XLEN(XLEN), .BI_SPACES(BI_SPACES), .BI_OPS(BI_OPS)) u_bi (
        .opc(ins_opcode), .funct3(ins_funct3), .a(ins_rs1), .b(ins_rs2),
        .hit(bi_hit), .result(bi_result)
    );

    cfu_seq #(.XLEN(XLEN)) u_seq (
        .clk(clk), .rst(rst),
        .ins_valid(ins_valid), .ins_custom(ins_custom),
        .ins_funct({ins_funct7, ins_funct3}),
        .ins_rs1(ins_rs1), .ins_rs2(ins_rs2),
        .sel(sel), .bi_hit(bi_hit), .bi_result(bi_result),
        .busy(busy), .req_valid(req_valid), .req_ready(req_ready),
        .req_funct(req_funct), .req_op_a(req_op_a), .req_op_b(req_op_b),
        .req_cfu_id(req_cfu_id), .req_state_id(req_state_id),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_data(rsp_data), .rsp_err(rsp_err),
        .wb_valid(wb_valid), .wb_data(wb_data), .trap(trap), .bi_fire(bi_fire)
    );
endmodule

// File: rtl/cfu_dispatch_chk.sv
module cfu_dispatch_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            ins_valid,
    input logic            ins_custom,
    input logic            sel_en,
    input logic            busy,
    input logic            req_valid,
    input logic            req_ready,
    input logic [7:0]      req_cfu_id,
    input logic [7:0]      req_state_id,
    input logic [XLEN-1:0] req_op_a,
    input logic            rsp_valid,
    input logic            rsp_ready,
    input logic            rsp_err,
    input logic            wb_valid,
    input logic            trap,
    input logic            bi_fire
);
    // R3
    disabled_no_req_chk: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && ins_custom && !busy && !sel_en) |=> (!req_valid && !busy));

    // R7
    held_payload_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_cfu_id)
                                       && $stable(req_state_id) && $stable(req_op_a)));

    // R7
    single_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && rsp_ready) && ((req_valid || rsp_ready) == busy));

    // R9
    err_trap_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_ready && rsp_err) |=> (trap && !wb_valid));

    // R8
    rsp_wb_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_ready && !rsp_err) |=> (wb_valid && !busy));

    // R4
    bi_wb_chk: assert property (@(posedge clk) disable iff (rst)
        bi_fire |-> (wb_valid && !trap));

    // R5
    excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(trap && wb_valid));
endmodule

bind cfu_dispatch cfu_dispatch_chk #(.XLEN(XLEN)) i_chk (
    .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_custom(ins_custom),
    .sel_en(sel_en), .busy(busy), .req_valid(req_valid), .req_ready(req_ready),
    .req_cfu_id(req_cfu_id), .req_state_id(req_state_id), .req_op_a(req_op_a),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_err(rsp_err),
    .wb_valid(wb_valid), .trap(trap), .bi_fire(bi_fire)
);

// File: tb/test_cfu_dispatch.sv
module test_cfu_dispatch;
    localparam logic [11:0] SADDR = 12'hBC0;
    localparam logic [6:0] C0 = 7'h0B, C1 = 7'h2B, C2 = 7'h5B, OP = 7'h33;

    logic clk = 1'b0, rst = 1'b1;
    logic csr_we = 0; logic [11:0] csr_addr = 0; logic [31:0] csr_wdata = 0, csr_rdata;
    logic ins_valid = 0; logic [6:0] ins_opcode = 0, ins_funct7 = 0; logic [2:0] ins_funct3 = 0;
    logic [31:0] ins_rs1 = 0, ins_rs2 = 0;
    logic busy, req_valid, req_ready = 0, rsp_valid = 0, rsp_ready, rsp_err = 0;
    logic [9:0] req_funct; logic [31:0] req_op_a, req_op_b, rsp_data = 0, wb_data;
    logic [7:0] req_cfu_id, req_state_id;
    logic wb_valid, trap, bi_fire;

    int total = 0, bad = 0;
    bit m_en = 0; logic [7:0] m_cfu = 0, m_st = 0;

    always #5 clk = ~clk;

    cfu_dispatch i_cfu_dispatch (
        .clk(clk), .rst(rst), .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .ins_valid(ins_valid), .ins_opcode(ins_opcode),
        .ins_funct3(ins_funct3), .ins_funct7(ins_funct7), .ins_rs1(ins_rs1), .ins_rs2(ins_rs2),
        .busy(busy), .req_valid(req_valid), .req_ready(req_ready), .req_funct(req_funct),
        .req_op_a(req_op_a), .req_op_b(req_op_b), .req_cfu_id(req_cfu_id),
        .req_state_id(req_state_id), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_data(rsp_data), .rsp_err(rsp_err), .wb_valid(wb_valid), .wb_data(wb_data),
        .trap(trap), .bi_fire(bi_fire));

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit m_bi_hit(logic [6:0] o, logic [2:0] f3);
        return (o == C0 || o == C1) && f3 < 3'd4;
    endfunction

    function automatic logic [31:0] m_bi(logic [2:0] f3, logic [31:0] a, logic [31:0] b);
        logic [4:0] s = b[4:0];
        case (f3)
            3'd0: return a + b;
            3'd1: return a ^ b;
            3'd2: return (a < b) ? a : b;
            default: return (s == 0) ? a : ((a << s) | (a >> (6'd32 - {1'b0, s})));
        endcase
    endfunction

    task automatic csr_write(input logic [11:0] ad, input logic [31:0] d);
        @(negedge clk);
        csr_we = 1; csr_addr = ad; csr_wdata = d;
        @(negedge clk);
        csr_we = 0;
        if (ad == SADDR) begin m_en = d[0]; m_cfu = d[15:8]; m_st = d[23:16]; end
    endtask

    task automatic csr_check(input logic [11:0] ad);
        logic [31:0] e;
        e = (ad == SADDR) ? {8'h0, m_st, m_cfu, 7'h0, m_en} : 32'h0;
        csr_addr = ad; #1;
        chk(csr_rdata === e, "R2 readback", {32'h0, csr_rdata}, {32'h0, e});
    endtask

    task automatic run_ins(input logic [6:0] o, input logic [2:0] f3, input logic [6:0] f7,
                           input logic [31:0] a, input logic [31:0] b, input int rdly,
                           input int pdly, input bit err, input logic [31:0] rd,
                           input bit mid, input logic [31:0] midv);
        bit cust;
        logic [7:0] ec, es;
        @(negedge clk);
        ins_valid = 1; ins_opcode = o; ins_funct3 = f3; ins_funct7 = f7; ins_rs1 = a; ins_rs2 = b;
        cust = (o == C0 || o == C1 || o == C2);
        ec = m_cfu; es = m_st;
        @(negedge clk);
        ins_valid = 0;
        if (!cust) begin
            chk(!wb_valid && !trap && !busy && !req_valid, "R11 ignored",
                {60'h0, wb_valid, trap, busy, req_valid}, 64'h0);
        end else if (!m_en) begin
            chk(!req_valid && !busy, "R3 no request", {62'h0, req_valid, busy}, 64'h0);
            if (m_bi_hit(o, f3)) begin
                chk(wb_valid && bi_fire && !trap && wb_data === m_bi(f3, a, b), "R4 built-in",
                    {29'h0, wb_valid, bi_fire, trap, wb_data}, {32'h6, m_bi(f3, a, b)});
            end else begin
                chk(trap && !wb_valid && !bi_fire, "R5 trap",
                    {61'h0, trap, wb_valid, bi_fire}, 64'h4);
            end
        end else begin
            chk(req_valid && busy && req_funct === {f7, f3} && req_op_a === a && req_op_b === b
                && req_cfu_id === ec && req_state_id === es, "R6 request",
                {req_funct, req_cfu_id, req_state_id, req_op_a[29:0]},
                {f7, f3, ec, es, a[29:0]});
            for (int i = 0; i < rdly; i++) begin
                if (i == 0 && mid) begin csr_we = 1; csr_addr = SADDR; csr_wdata = midv; end
                @(negedge clk);
                if (i == 0 && mid) begin
                    csr_we = 0; m_en = midv[0]; m_cfu = midv[15:8]; m_st = midv[23:16];
                end
                chk(req_valid && busy && req_cfu_id === ec && req_state_id === es && req_op_b === b,
                    mid ? "R10 ids held" : "R7 held", {46'h0, req_valid, busy, req_cfu_id, req_state_id},
                    {46'h0, 2'b11, ec, es});
            end
            req_ready = 1;
            @(negedge clk);
            req_ready = 0;
            chk(!req_valid && rsp_ready && busy, "R7 one outstanding",
                {61'h0, req_valid, rsp_ready, busy}, 64'h3);
            for (int i = 0; i < pdly; i++) begin
                @(negedge clk);
                chk(busy && !wb_valid && !trap, "R7 busy wait", {61'h0, busy, wb_valid, trap}, 64'h4);
            end
            rsp_valid = 1; rsp_data = rd; rsp_err = err;
            @(negedge clk);
            rsp_valid = 0; rsp_err = 0;
            if (err)
                chk(trap && !wb_valid && !busy, "R9 error trap", {61'h0, trap, wb_valid, busy}, 64'h4);
            else
                chk(wb_valid && !trap && !busy && wb_data === rd, "R8 writeback",
                    {29'h0, wb_valid, trap, busy, wb_data}, {32'h4, rd});
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk(!req_valid && !rsp_ready && !wb_valid && !trap && !bi_fire && !busy, "R1 reset outputs",
            {58'h0, req_valid, rsp_ready, wb_valid, trap, bi_fire, busy}, 64'h0);
        csr_check(SADDR);
        // R2 layout, unused bits zero, other address
        csr_write(SADDR, 32'hFFAB_CD00);
        csr_check(SADDR);
        csr_write(12'h7C0, 32'h0000_0001);
        csr_check(SADDR);
        csr_check(12'h7C0);
        // R3/R4/R5 with ids stored but disabled
        run_ins(C0, 3'd0, 7'h00, 32'hFFFF_FFFF, 32'h2, 0, 0, 0, 0, 0, 0);
        run_ins(C1, 3'd1, 7'h11, 32'hA5A5_0F0F, 32'hFFFF_0000, 0, 0, 0, 0, 0, 0);
        run_ins(C0, 3'd2, 7'h00, 32'h8000_0000, 32'h7FFF_FFFF, 0, 0, 0, 0, 0, 0);
        run_ins(C1, 3'd3, 7'h00, 32'h8000_0001, 32'd4, 0, 0, 0, 0, 0, 0);
        run_ins(C0, 3'd3, 7'h00, 32'h1234_5678, 32'd32, 0, 0, 0, 0, 0, 0);
        run_ins(C2, 3'd0, 7'h00, 32'h1, 32'h1, 0, 0, 0, 0, 0, 0);
        run_ins(C0, 3'd4, 7'h00, 32'h1, 32'h1, 0, 0, 0, 0, 0, 0);
        run_ins(C1, 3'd7, 7'h00, 32'h1, 32'h1, 0, 0, 0, 0, 0, 0);
        run_ins(OP, 3'd0, 7'h00, 32'h1, 32'h1, 0, 0, 0, 0, 0, 0);
        // enabled path
        csr_write(SADDR, 32'h0042_1701);
        csr_check(SADDR);
        run_ins(C2, 3'd5, 7'h3A, 32'hDEAD_BEEF, 32'h0BAD_F00D, 0, 0, 0, 32'h1111_2222, 0, 0);
        run_ins(C0, 3'd0, 7'h01, 32'h5, 32'h6, 3, 2, 0, 32'h3333_4444, 0, 0);
        run_ins(C1, 3'd6, 7'h7F, 32'h7, 32'h8, 1, 0, 1, 32'h0, 0, 0);
        // R10 selector rewrite while in flight, then next instruction uses new value
        run_ins(C0, 3'd1, 7'h02, 32'h9, 32'hA, 2, 1, 0, 32'h5555_6666, 1, 32'h0099_8801);
        run_ins(C2, 3'd2, 7'h04, 32'hB, 32'hC, 0, 0, 0, 32'h7777_8888, 0, 0);
        run_ins(OP, 3'd0, 7'h00, 32'h1, 32'h1, 0, 0, 0, 0, 0, 0);
        // random mix
        for (int n = 0; n < 300; n++) begin
            logic [6:0] o;
            int k = $urandom_range(0, 4);
            if ($urandom_range(0, 9) == 0)
                csr_write(SADDR, {8'h0, 8'($urandom), 8'($urandom), 7'h0, 1'($urandom)});
            o = (k == 0) ? C0 : (k == 1) ? C1 : (k == 2) ? C2 : (k == 3) ? C0 : OP;
            run_ins(o, 3'($urandom), 7'($urandom), $urandom, $urandom, $urandom_range(0, 3),
                    $urandom_range(0, 3), ($urandom_range(0, 7) == 0), $urandom, 0, 0);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule